// File: doc/BRIEF.md
# Page-Mode DRAM Burst Sequencer

This block serves four-beat read bursts from an asynchronous-style DRAM array. A requester presents a row and a starting column on a request/acknowledge port. The sequencer opens the row and then walks four column addresses. For each beat it counts clock cycles according to one of four timing modes. It drives the array's row and column address and takes the read word back from the array on `memData`. Each word goes out on `beatData` with a one-cycle `beatValid` strobe. The strobe falls on the last cycle of its beat. The fourth strobe also raises `burstDone`.

The mode controls two things: how long the later beats take, and how the data-output enable behaves between beats. In the two page modes the enable opens only in a beat's delivery cycle and closes again right after it. In the two hold modes it stays open, and the last word delivered stays on the output until the next word replaces it. After every burst there is a short precharge interval, and no new request is acknowledged during it. The array model is not part of the block. The bench builds it as a combinational function of the address outputs.

Top module: `dram_burst_seq`

## Requirements
- R1: While reset is applied and just after it, `reqAck` is 1 and `beatValid`, `burstDone` and `outEnable` are 0.
- R2: A request is accepted at a rising edge where `reqValid` and `reqAck` are both 1. `reqAck` is 0 from the next cycle until the precharge ends.
- R3: The first beat of every burst delivers its word in the 5th cycle after the accepting edge, in every mode.
- R4: Each later beat lasts a number of cycles set by `modeSel` at acceptance: 0 (plain page) 5 cycles, 1 (fast page) 3, 2 (extended data out) 2, 3 (synchronous) 1.
- R5: `beatValid` is high for exactly one cycle per beat, four times per burst. `burstDone` is high only together with the fourth strobe.
- R6: The beats read columns start, start+1, start+2, start+3, with the increment confined to the two low column bits (a wrap inside the aligned group of four). The row stays fixed. The word on `beatData` with each strobe equals the array word at that row and column.
- R7: In modes 0 and 1, `outEnable` is high exactly in the `beatValid` cycles, and `beatData` reads 0 whenever `outEnable` is low.
- R8: In modes 2 and 3, `outEnable` rises with the first strobe and stays high through the fourth. Between strobes, `beatData` keeps the previously delivered word. `outEnable` is low once the burst has finished.
- R9: After the fourth strobe there is exactly one precharge cycle with `reqAck` low. `reqAck` then returns to 1, so a held request is accepted at the end of the second cycle after the done strobe.
- R10: `modeSel` is read only at acceptance. A change to it during a burst alters neither the beat timing nor the enable waveform of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request present |
| reqAck | output | 1 | Sequencer idle; a request is taken at this edge |
| reqRow | input | ROW_W | Row to open for the burst |
| reqCol | input | COL_W | Starting column of the burst |
| modeSel | input | 2 | Timing mode: 0 plain page, 1 fast page, 2 extended data out, 3 synchronous |
| memRow | output | ROW_W | Row address to the array |
| memCol | output | COL_W | Column address to the array |
| memData | input | DATA_W | Read word returned by the array for the current address |
| beatData | output | DATA_W | Delivered word, gated by the output enable |
| beatValid | output | 1 | One-cycle strobe on the last cycle of each beat |
| burstDone | output | 1 | High with the strobe of the fourth beat |
| outEnable | output | 1 | Data-output enable |

## Verification
The same burst is issued in all four modes. Comparing the strobe positions tells 5-5-5-5, 5-3-3-3, 5-2-2-2 and 5-1-1-1 apart. The enable and data waveform, checked in every cycle, tells the close-after-each-beat behaviour from the hold-until-replaced behaviour. Starting columns at 0, in the middle of a group and at the top of the column space make the wrap inside a group of four visible against a plain increment. Other runs flip `modeSel` in the middle of a burst, and hold a request back to back, to expose mode resampling and any precharge cycle that is skipped or too long.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    MODE_PAGE = 2'd0,
    MODE_FAST = 2'd1,
    MODE_EDO  = 2'd2,
    MODE_SYNC = 2'd3
  } burstMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_PRE  = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptReq;   // request taken at this edge
    logic nextBeat;    // current beat ends, another follows
    logic finalCycle;  // delivery cycle of the current beat
    logic oeOn;        // data-output enable
  } seqStrobe_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 4,
  parameter int FIRST_CYC = 5,
  parameter int PAGE_CYC  = 5,
  parameter int FAST_CYC  = 3,
  parameter int EDO_CYC   = 2,
  parameter int SYNC_CYC  = 1,
  parameter int PRE_CYC   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] modeSel,
  output logic       reqAck,
  output logic       beatValid,
  output logic       burstDone,
  output seqStrobe_t strobe
);

  localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  seqState_e        state;
  burstMode_e       modeReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] laterLoad;
  logic [IDX_W-1:0] beatIdx;
  logic             holdMode;
  logic             finalCycle;
  logic             accept;

  always_comb begin
    unique case (modeReg)
      MODE_PAGE: laterLoad = CNT_W'(PAGE_CYC - 1);
      MODE_FAST: laterLoad = CNT_W'(FAST_CYC - 1);
      MODE_EDO:  laterLoad = CNT_W'(EDO_CYC - 1);
      default:   laterLoad = CNT_W'(SYNC_CYC - 1);
    endcase
  end

  assign accept     = reqValid && (state == ST_IDLE);
  assign finalCycle = (state == ST_BEAT) && (cnt == '0);
  assign holdMode   = (modeReg == MODE_EDO) || (modeReg == MODE_SYNC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      beatIdx <= '0;
      modeReg <= MODE_PAGE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_BEAT;
            cnt     <= CNT_W'(FIRST_CYC - 1);
            beatIdx <= '0;
            modeReg <= burstMode_e'(modeSel);
          end
        end
        ST_BEAT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (beatIdx == LAST_IDX) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(PRE_CYC - 1);
          end else begin
            beatIdx <= beatIdx + 1'b1;
            cnt     <= laterLoad;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= ST_IDLE;
        end
      endcase
    end
  end

  assign reqAck    = (state == ST_IDLE);
  assign beatValid = finalCycle;
  assign burstDone = finalCycle && (beatIdx == LAST_IDX);

  assign strobe.acceptReq  = accept;
  assign strobe.nextBeat   = finalCycle && (beatIdx != LAST_IDX);
  assign strobe.finalCycle = finalCycle;
  assign strobe.oeOn       = finalCycle ||
                             (holdMode && (state == ST_BEAT) && (beatIdx != '0));

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_seq_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] memData,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  output logic [DATA_W-1:0] beatData
);

  localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colBase;
  logic [IDX_W-1:0]  colOff;
  logic [DATA_W-1:0] heldData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg   <= '0;
      colBase  <= '0;
      colOff   <= '0;
      heldData <= '0;
    end else begin
      if (strobe.acceptReq) begin
        rowReg  <= reqRow;
        colBase <= reqCol;
        colOff  <= '0;
      end else if (strobe.nextBeat) begin
        colOff <= colOff + 1'b1;
      end
      if (strobe.finalCycle) heldData <= memData;
    end
  end

  // increment stays inside the aligned group of BURST_LEN columns
  assign memRow = rowReg;
  assign memCol = {colBase[COL_W-1:IDX_W], colBase[IDX_W-1:0] + colOff};

  always_comb begin
    if (!strobe.oeOn)           beatData = '0;
    else if (strobe.finalCycle) beatData = memData;
    else                        beatData = heldData;
  end

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 4,
  parameter int FIRST_CYC = 5,
  parameter int PAGE_CYC  = 5,
  parameter int FAST_CYC  = 3,
  parameter int EDO_CYC   = 2,
  parameter int SYNC_CYC  = 1,
  parameter int PRE_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqAck,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [1:0]        modeSel,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] beatData,
  output logic              beatValid,
  output logic              burstDone,
  output logic              outEnable
);

  seqStrobe_t strobe;

  burst_ctrl #(
    .BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .FIRST_CYC(FIRST_CYC),
    .PAGE_CYC(PAGE_CYC), .FAST_CYC(FAST_CYC), .EDO_CYC(EDO_CYC),
    .SYNC_CYC(SYNC_CYC), .PRE_CYC(PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeSel(modeSel),
    .reqAck(reqAck), .beatValid(beatValid), .burstDone(burstDone),
    .strobe(strobe)
  );

  burst_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRow(reqRow),
    .reqCol(reqCol), .memData(memData), .memRow(memRow),
    .memCol(memCol), .beatData(beatData)
  );

  assign outEnable = strobe.oeOn;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqAck,
  input logic              beatValid,
  input logic              burstDone,
  input logic              outEnable,
  input logic [DATA_W-1:0] beatData
);

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck) |=> !reqAck); // R2

  AST_FIRST_BEAT_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck) |=> !beatValid); // R3

  AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> beatValid); // R5

  AST_OE_ON_DELIVERY: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> outEnable); // R7

  AST_HOLD_BETWEEN_BEATS: assert property (@(posedge clk) disable iff (!rstN)
    (outEnable && !beatValid && $past(outEnable)) |-> $stable(beatData)); // R8

  AST_OE_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> !outEnable); // R8

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !reqAck); // R9

endmodule

bind dram_burst_seq burst_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
  .beatValid(beatValid), .burstDone(burstDone), .outEnable(outEnable),
  .beatData(beatData)
);

// File: tb/dram_burst_seq_tb.sv
module dram_burst_seq_tb;

  localparam int ROW_W  = 8;
  localparam int COL_W  = 6;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqAck;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic [1:0]        modeSel = 2'd0;
  logic [ROW_W-1:0]  memRow;
  logic [COL_W-1:0]  memCol;
  logic [DATA_W-1:0] memData;
  logic [DATA_W-1:0] beatData;
  logic              beatValid;
  logic              burstDone;
  logic              outEnable;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  function automatic logic [DATA_W-1:0] memWord(input logic [ROW_W-1:0] r,
                                                input logic [COL_W-1:0] c);
    return {r, 2'b00, c} ^ 16'hA5C3;
  endfunction

  assign memData = memWord(memRow, memCol);

  dram_burst_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
    .reqRow(reqRow), .reqCol(reqCol), .modeSel(modeSel),
    .memRow(memRow), .memCol(memCol), .memData(memData),
    .beatData(beatData), .beatValid(beatValid), .burstDone(burstDone),
    .outEnable(outEnable)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int laterCycles(input logic [1:0] m);
    case (m)
      2'd0: return 5;
      2'd1: return 3;
      2'd2: return 2;
      default: return 1;
    endcase
  endfunction

  // one burst; flipMode changes modeSel right after acceptance (R10)
  task automatic runBurst(input logic [1:0] mode, input logic [ROW_W-1:0] row,
                          input logic [COL_W-1:0] col, input bit flipMode,
                          input bit holdReq);
    int len;
    int lastCyc;
    int beatNo;
    logic [DATA_W-1:0] prevWord;
    len = laterCycles(mode);
    lastCyc = 5 + 3 * len;
    beatNo = 0;
    prevWord = '0;
    @(negedge clk);
    while (!reqAck) @(negedge clk);
    reqValid = 1'b1;
    modeSel  = mode;
    reqRow   = row;
    reqCol   = col;
    @(negedge clk);
    if (!holdReq) reqValid = 1'b0;
    if (flipMode) modeSel = ~mode;
    for (int cyc = 1; cyc <= lastCyc + 2; cyc++) begin
      logic expValid;
      logic expOe;
      logic [DATA_W-1:0] expData;
      logic [COL_W-1:0] colK;
      expValid = (cyc >= 5) && (cyc <= lastCyc) && (((cyc - 5) % len) == 0);
      if (mode <= 2'd1) expOe = expValid;
      else              expOe = (cyc >= 5) && (cyc <= lastCyc);
      colK = {col[COL_W-1:2], col[1:0] + 2'(beatNo)};
      if (!expOe)        expData = '0;
      else if (expValid) expData = memWord(row, colK);
      else               expData = prevWord;
      if (cyc == 1) chk("R2", "ack after accept", 32'(reqAck), 32'd0);
      if (cyc == 5) chk("R3", "first beat strobe", 32'(beatValid), 32'd1);
      chk(mode == 2'd0 ? "R4" : "R4", "beat strobe timing", 32'(beatValid), 32'(expValid));
      chk("R5", "done strobe", 32'(burstDone), 32'(cyc == lastCyc));
      chk(mode <= 2'd1 ? "R7" : "R8", "output enable", 32'(outEnable), 32'(expOe));
      if (expValid) begin
        chk("R6", "column address", 32'(memCol), 32'(colK));
        chk("R6", "row address", 32'(memRow), 32'(row));
      end
      chk(mode <= 2'd1 ? "R7" : "R8", "beat data", 32'(beatData), 32'(expData));
      if (flipMode && expValid) chk("R10", "mode ignored mid-burst", 32'(beatValid), 32'd1);
      if (cyc == lastCyc + 1) chk("R9", "ack in precharge", 32'(reqAck), 32'd0);
      if (cyc == lastCyc + 2) chk("R9", "ack after precharge", 32'(reqAck), 32'd1);
      if (expValid) begin
        prevWord = expData;
        beatNo++;
      end
      if (cyc < lastCyc + 2) @(negedge clk);
    end
    modeSel = mode;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "ack in reset", 32'(reqAck), 32'd1);
    chk("R1", "valid in reset", 32'(beatValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ack after reset", 32'(reqAck), 32'd1);
    chk("R1", "valid after reset", 32'(beatValid), 32'd0);
    chk("R1", "done after reset", 32'(burstDone), 32'd0);
    chk("R1", "enable after reset", 32'(outEnable), 32'd0);
  endtask

  task automatic testAllModes();
    runBurst(2'd0, 8'h12, 6'h00, 1'b0, 1'b0);
    runBurst(2'd1, 8'h34, 6'h05, 1'b0, 1'b0);
    runBurst(2'd2, 8'h56, 6'h3F, 1'b0, 1'b0);
    runBurst(2'd3, 8'hA9, 6'h1A, 1'b0, 1'b0);
  endtask

  task automatic testModeFlip();
    runBurst(2'd1, 8'h0F, 6'h22, 1'b1, 1'b0);  // R10
    runBurst(2'd2, 8'hF0, 6'h13, 1'b1, 1'b0);  // R10
  endtask

  // request held high: next acceptance right after the single precharge cycle
  task automatic testBackToBack();
    runBurst(2'd3, 8'h77, 6'h2E, 1'b0, 1'b1);
    // reqAck is high with reqValid held: this edge accepts (R9)
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9", "held request accepted", 32'(reqAck), 32'd0);
    while (!reqAck) @(negedge clk);
    runBurst(2'd0, 8'h01, 6'h3D, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testAllModes();
    testModeFlip();
    testBackToBack();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2ms;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule